// File: doc/BRIEF.md
# Interrupt and Reset Entry Sequencer for an 8-bit CPU

This block runs the multi-cycle entry and exit sequences that sit around normal instruction execution in an 8-bit accumulator CPU with a 16-bit address space. After reset it fetches the start address from a fixed vector. At an instruction boundary it can take a non-maskable interrupt, a maskable interrupt or a software break. For each of these it saves the return address and the status byte on the stack in page one, then loads the new program counter from a vector. It also runs the return-from-interrupt sequence, which restores status and program counter from the stack.

The core passes in its current program counter, stack pointer and status byte, and raises a boundary strobe when it may be interrupted. It then waits while `busy` is high. When `done` pulses, the core takes the new register values from the outputs, together with an entry kind code and the number of CPU cycles the entry costs. Memory is accessed through a single synchronous port. Read data returns one clock after the address is presented.

Top module: `int_entry_seq`

## Requirements
- R1: On leaving reset, the block reads 0xFFFC and then 0xFFFD and pulses `done`. At that pulse `pcOut` holds the little-endian vector, `spOut` is 0xFF, `statusOut` is 0x26, `entryKind` is 1 (reset) and `entryCost` is 6. No memory write occurs.
- R2: The status byte uses bit 0 carry, bit 1 zero, bit 2 interrupt mask, bit 3 decimal, bit 4 break, bit 6 overflow and bit 7 negative. Bit 5 of `statusOut` always reads 1.
- R3: On an NMI or an unmasked IRQ, the block writes PC high to 0x0100+S, PC low to 0x0100+(S-1) and status with bit 4 cleared (bit 5 set) to 0x0100+(S-2). It then ends with S-3, the pushed status with bit 2 set, cost 7, and the PC read low byte then high byte from 0xFFFA/0xFFFB (NMI, kind 2) or 0xFFFE/0xFFFF (IRQ, kind 3).
- R4: The stack pointer wraps modulo 256 on push and pull, so stack addresses never leave page 0x01. The skipped-byte PC increment of a break also wraps modulo 65536.
- R5: When an NMI is pending and IRQ is also high at a boundary, the NMI is taken first. The IRQ can be taken at a later boundary.
- R6: A rising edge on `nmiLine` is remembered until a boundary takes it. A line held high produces exactly one entry.
- R7: An IRQ taken while status bit 2 of `statusIn` is 1 performs no memory write. It pulses `done` with kind 4 and cost 7, and returns `pcIn`, `spIn` and `statusIn` (bit 5 forced) unchanged.
- R8: A break pushes `pcIn`+1, then status with bit 4 set, and sets bit 2. It uses the IRQ vector, with kind 5 and cost 7.
- R9: Return-from-interrupt reads status from 0x0100+(S+1), PC low from S+2 and PC high from S+3. It ends with S+3 and with bits 4 and 5 of the status forced to 1, kind 6 and cost 6.
- R10: Requests are sampled only on a clock where `boundary` is high and the block is idle. The priority order is NMI, then IRQ, then break, then return.
- R11: `done` is a single-clock pulse, raised only while the block is idle. The register outputs, kind and cost are valid while `done` is high.
- R12: The memory port never reads and writes in the same cycle, and every write targets page 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; its release starts the reset sequence |
| boundary | input | 1 | Instruction boundary strobe from the core |
| nmiLine | input | 1 | Non-maskable request line (edge latched) |
| irqLine | input | 1 | Maskable request line (level) |
| brkReq | input | 1 | Break opcode decoded |
| rtiReq | input | 1 | Return-from-interrupt opcode decoded |
| pcIn | input | 16 | Current PC (for break: address after the opcode) |
| spIn | input | 8 | Current stack pointer |
| statusIn | input | 8 | Current status byte |
| memAddr | output | 16 | Memory address |
| memWrEn | output | 1 | Memory write enable |
| memRdEn | output | 1 | Memory read enable |
| memWrData | output | 8 | Memory write data |
| memRdData | input | 8 | Read data, one clock after the address |
| pcOut | output | 16 | Resulting program counter |
| spOut | output | 8 | Resulting stack pointer |
| statusOut | output | 8 | Resulting status byte |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-clock completion pulse |
| entryKind | output | 3 | 1 reset, 2 NMI, 3 IRQ, 4 masked IRQ, 5 break, 6 return |
| entryCost | output | 4 | CPU cycles charged for the sequence |

## Verification
On every cycle, the assertions check that `done` lasts one clock and falls only while idle, and that bit 5 of the status stays set. They also check the memory port rules: no write while a reset or masked-IRQ sequence is running, writes only to page one, and never a read and a write together. At each completion they check the mask bit after an entry and the break bit after a return. Push order, byte values, stack wrap, vector choice, NMI edge latching and request priority depend on data across whole sequences. Only the bench scenarios show these, by comparing the stack memory and the final registers with values computed independently.

// File: rtl/int_entry_pkg.sv
`timescale 1ns/1ps
package int_entry_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int COST_W = 4;
  localparam int KIND_W = 3;

  localparam logic [DATA_W-1:0] STACK_PAGE = 8'h01;
  localparam logic [ADDR_W-1:0] VEC_NMI = 16'hFFFA;
  localparam logic [ADDR_W-1:0] VEC_RST = 16'hFFFC;
  localparam logic [ADDR_W-1:0] VEC_IRQ = 16'hFFFE;

  localparam int FLAG_C   = 0;
  localparam int FLAG_Z   = 1;
  localparam int FLAG_I   = 2;
  localparam int FLAG_D   = 3;
  localparam int FLAG_B   = 4;
  localparam int FLAG_ONE = 5;
  localparam int FLAG_V   = 6;
  localparam int FLAG_N   = 7;

  localparam logic [DATA_W-1:0] STATUS_AT_RESET =
    DATA_W'((1 << FLAG_ONE) | (1 << FLAG_I) | (1 << FLAG_Z));

  localparam logic [COST_W-1:0] COST_RESET = 4'd6;
  localparam logic [COST_W-1:0] COST_INT   = 4'd7;
  localparam logic [COST_W-1:0] COST_RET   = 4'd6;

  typedef enum logic [KIND_W-1:0] {
    KIND_NONE       = 3'd0,
    KIND_RESET      = 3'd1,
    KIND_NMI        = 3'd2,
    KIND_IRQ        = 3'd3,
    KIND_IRQ_MASKED = 3'd4,
    KIND_BRK        = 3'd5,
    KIND_RET        = 3'd6
  } kind_e;

  typedef enum logic [1:0] {VSEL_NMI, VSEL_RST, VSEL_IRQ} vsel_e;

  typedef enum logic [2:0] {
    MOP_NONE, MOP_PUSH_HI, MOP_PUSH_LO, MOP_PUSH_ST, MOP_PULL, MOP_VEC_LO, MOP_VEC_HI
  } mop_e;

  typedef enum logic [1:0] {BMODE_KEEP, BMODE_CLR, BMODE_SET} bmode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   capture;   // load context from the core inputs
    logic   skipByte;  // add one to the captured PC
    bmode_e bMode;     // break bit treatment on capture
    mop_e   memOp;     // memory operation this cycle
    vsel_e  vecSel;    // vector used by MOP_VEC_*
    logic   takeLo;    // PC low byte from read data
    logic   takeHi;    // PC high byte from read data
    logic   takeSt;    // status from read data
    logic   setI;      // set interrupt mask
  } ctl_s;
endpackage

// File: rtl/int_entry_ctrl.sv
`timescale 1ns/1ps
module int_entry_ctrl
  import int_entry_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              boundary,
  input  logic              nmiLine,
  input  logic              irqLine,
  input  logic              brkReq,
  input  logic              rtiReq,
  input  logic              maskBit,
  output ctl_s              ctl,
  output logic              busy,
  output logic              done,
  output logic [KIND_W-1:0] entryKind,
  output logic [COST_W-1:0] entryCost
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_PUSH_HI, ST_PUSH_LO, ST_PUSH_ST,
    ST_VEC_LO, ST_VEC_HI, ST_VEC_END,
    ST_PULL_ST, ST_PULL_LO, ST_PULL_HI, ST_PULL_END
  } state_e;

  state_e state, nextState;
  vsel_e  vecSelQ;
  kind_e  kindQ;
  logic [COST_W-1:0] costQ;
  logic nmiPrev, nmiPending, doneQ;
  logic nmiEdge, accept, takeNmi, takeIrq, takeBrk, takeRet, finishing;

  assign nmiEdge = nmiLine & ~nmiPrev;
  assign accept  = (state == ST_IDLE) & boundary;
  assign takeNmi = accept & nmiPending;
  assign takeIrq = accept & ~nmiPending & irqLine;
  assign takeBrk = accept & ~nmiPending & ~irqLine & brkReq;
  assign takeRet = accept & ~nmiPending & ~irqLine & ~brkReq & rtiReq;
  assign finishing = (state == ST_VEC_END) | (state == ST_PULL_END) | (takeIrq & maskBit);

  always_comb begin
    ctl = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (takeNmi) begin
          ctl.capture = 1'b1;
          ctl.bMode   = BMODE_CLR;
          nextState   = ST_PUSH_HI;
        end else if (takeIrq) begin
          ctl.capture = 1'b1;
          if (maskBit) begin
            ctl.bMode = BMODE_KEEP;
          end else begin
            ctl.bMode = BMODE_CLR;
            nextState = ST_PUSH_HI;
          end
        end else if (takeBrk) begin
          ctl.capture  = 1'b1;
          ctl.skipByte = 1'b1;
          ctl.bMode    = BMODE_SET;
          nextState    = ST_PUSH_HI;
        end else if (takeRet) begin
          ctl.capture = 1'b1;
          ctl.bMode   = BMODE_KEEP;
          nextState   = ST_PULL_ST;
        end
      end
      ST_PUSH_HI: begin ctl.memOp = MOP_PUSH_HI; nextState = ST_PUSH_LO; end
      ST_PUSH_LO: begin ctl.memOp = MOP_PUSH_LO; nextState = ST_PUSH_ST; end
      ST_PUSH_ST: begin
        ctl.memOp = MOP_PUSH_ST;
        ctl.setI  = 1'b1;
        nextState = ST_VEC_LO;
      end
      ST_VEC_LO: begin
        ctl.memOp  = MOP_VEC_LO;
        ctl.vecSel = vecSelQ;
        nextState  = ST_VEC_HI;
      end
      ST_VEC_HI: begin
        ctl.memOp  = MOP_VEC_HI;
        ctl.vecSel = vecSelQ;
        ctl.takeLo = 1'b1;
        nextState  = ST_VEC_END;
      end
      ST_VEC_END: begin ctl.takeHi = 1'b1; nextState = ST_IDLE; end
      ST_PULL_ST: begin ctl.memOp = MOP_PULL; nextState = ST_PULL_LO; end
      ST_PULL_LO: begin
        ctl.memOp  = MOP_PULL;
        ctl.takeSt = 1'b1;
        nextState  = ST_PULL_HI;
      end
      ST_PULL_HI: begin
        ctl.memOp  = MOP_PULL;
        ctl.takeLo = 1'b1;
        nextState  = ST_PULL_END;
      end
      ST_PULL_END: begin ctl.takeHi = 1'b1; nextState = ST_IDLE; end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_VEC_LO;
      vecSelQ    <= VSEL_RST;
      kindQ      <= KIND_RESET;
      costQ      <= COST_RESET;
      doneQ      <= 1'b0;
      nmiPrev    <= 1'b0;
      nmiPending <= 1'b0;
    end else begin
      state      <= nextState;
      doneQ      <= finishing;
      nmiPrev    <= nmiLine;
      nmiPending <= (nmiPending & ~takeNmi) | nmiEdge;
      if (takeNmi) begin
        vecSelQ <= VSEL_NMI;
        kindQ   <= KIND_NMI;
        costQ   <= COST_INT;
      end else if (takeIrq) begin
        vecSelQ <= VSEL_IRQ;
        kindQ   <= maskBit ? KIND_IRQ_MASKED : KIND_IRQ;
        costQ   <= COST_INT;
      end else if (takeBrk) begin
        vecSelQ <= VSEL_IRQ;
        kindQ   <= KIND_BRK;
        costQ   <= COST_INT;
      end else if (takeRet) begin
        kindQ   <= KIND_RET;
        costQ   <= COST_RET;
      end
    end
  end

  assign busy      = (state != ST_IDLE);
  assign done      = doneQ;
  assign entryKind = kindQ;
  assign entryCost = costQ;
endmodule

// File: rtl/int_entry_dp.sv
`timescale 1ns/1ps
module int_entry_dp
  import int_entry_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctl_s              ctl,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [DATA_W-1:0] spIn,
  input  logic [DATA_W-1:0] statusIn,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWrEn,
  output logic              memRdEn,
  output logic [DATA_W-1:0] memWrData,
  output logic [ADDR_W-1:0] pcOut,
  output logic [DATA_W-1:0] spOut,
  output logic [DATA_W-1:0] statusOut
);
  localparam int HALF = ADDR_W / 2;

  logic [ADDR_W-1:0] pcQ, vecBase;
  logic [DATA_W-1:0] spQ, stQ, statusCap, spNext;

  assign spNext = spQ + DATA_W'(1);

  always_comb begin
    statusCap = statusIn;
    case (ctl.bMode)
      BMODE_CLR: statusCap[FLAG_B] = 1'b0;
      BMODE_SET: statusCap[FLAG_B] = 1'b1;
      default: ;
    endcase
    statusCap[FLAG_ONE] = 1'b1;
  end

  always_comb begin
    case (ctl.vecSel)
      VSEL_NMI: vecBase = VEC_NMI;
      VSEL_RST: vecBase = VEC_RST;
      default:  vecBase = VEC_IRQ;
    endcase
  end

  always_comb begin
    memAddr   = '0;
    memWrData = '0;
    memWrEn   = 1'b0;
    memRdEn   = 1'b0;
    case (ctl.memOp)
      MOP_PUSH_HI: begin memAddr = {STACK_PAGE, spQ}; memWrData = pcQ[ADDR_W-1:HALF]; memWrEn = 1'b1; end
      MOP_PUSH_LO: begin memAddr = {STACK_PAGE, spQ}; memWrData = pcQ[HALF-1:0];      memWrEn = 1'b1; end
      MOP_PUSH_ST: begin memAddr = {STACK_PAGE, spQ}; memWrData = stQ;                memWrEn = 1'b1; end
      MOP_PULL:    begin memAddr = {STACK_PAGE, spNext}; memRdEn = 1'b1; end
      MOP_VEC_LO:  begin memAddr = vecBase;              memRdEn = 1'b1; end
      MOP_VEC_HI:  begin memAddr = vecBase | ADDR_W'(1); memRdEn = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ <= '0;
      spQ <= '1;
      stQ <= STATUS_AT_RESET;
    end else begin
      if (ctl.capture) begin
        pcQ <= ctl.skipByte ? pcIn + ADDR_W'(1) : pcIn;
        spQ <= spIn;
        stQ <= statusCap;
      end
      case (ctl.memOp)
        MOP_PUSH_HI, MOP_PUSH_LO, MOP_PUSH_ST: spQ <= spQ - DATA_W'(1);
        MOP_PULL:                              spQ <= spNext;
        default: ;
      endcase
      if (ctl.setI) stQ[FLAG_I] <= 1'b1;
      if (ctl.takeSt) begin
        stQ           <= memRdData;
        stQ[FLAG_B]   <= 1'b1;
        stQ[FLAG_ONE] <= 1'b1;
      end
      if (ctl.takeLo) pcQ[HALF-1:0]      <= memRdData;
      if (ctl.takeHi) pcQ[ADDR_W-1:HALF] <= memRdData;
    end
  end

  assign pcOut     = pcQ;
  assign spOut     = spQ;
  assign statusOut = stQ;
endmodule

// File: rtl/int_entry_seq.sv
`timescale 1ns/1ps
module int_entry_seq
  import int_entry_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        boundary,
  input  logic        nmiLine,
  input  logic        irqLine,
  input  logic        brkReq,
  input  logic        rtiReq,
  input  logic [15:0] pcIn,
  input  logic [7:0]  spIn,
  input  logic [7:0]  statusIn,
  output logic [15:0] memAddr,
  output logic        memWrEn,
  output logic        memRdEn,
  output logic [7:0]  memWrData,
  input  logic [7:0]  memRdData,
  output logic [15:0] pcOut,
  output logic [7:0]  spOut,
  output logic [7:0]  statusOut,
  output logic        busy,
  output logic        done,
  output logic [2:0]  entryKind,
  output logic [3:0]  entryCost
);
  ctl_s ctl;

  int_entry_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .boundary(boundary), .nmiLine(nmiLine),
    .irqLine(irqLine), .brkReq(brkReq), .rtiReq(rtiReq),
    .maskBit(statusIn[FLAG_I]), .ctl(ctl), .busy(busy), .done(done),
    .entryKind(entryKind), .entryCost(entryCost)
  );

  int_entry_dp u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .pcIn(pcIn), .spIn(spIn),
    .statusIn(statusIn), .memRdData(memRdData), .memAddr(memAddr),
    .memWrEn(memWrEn), .memRdEn(memRdEn), .memWrData(memWrData),
    .pcOut(pcOut), .spOut(spOut), .statusOut(statusOut)
  );
endmodule

// File: rtl/int_entry_seq_chk.sv
`timescale 1ns/1ps
module int_entry_seq_chk
  import int_entry_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic [7:0] addrPage,
  input logic       memWrEn,
  input logic       memRdEn,
  input logic [7:0] statusOut,
  input logic       busy,
  input logic       done,
  input logic [2:0] entryKind
);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN) done |-> !busy);
  // R12
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rstN) !(memWrEn && memRdEn));
  // R12
  wr_page_chk: assert property (@(posedge clk) disable iff (!rstN) memWrEn |-> addrPage == STACK_PAGE);
  // R2
  one_bit_chk: assert property (@(posedge clk) disable iff (!rstN) statusOut[FLAG_ONE]);
  // R3
  mask_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && (entryKind == KIND_NMI || entryKind == KIND_IRQ || entryKind == KIND_BRK)) |-> statusOut[FLAG_I]);
  // R9
  ret_break_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && entryKind == KIND_RET) |-> statusOut[FLAG_B]);
  // R7
  masked_nowrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    (entryKind == KIND_IRQ_MASKED) |-> !memWrEn);
  // R1
  reset_nowrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    (entryKind == KIND_RESET) |-> !memWrEn);
endmodule

bind int_entry_seq int_entry_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .addrPage(memAddr[15:8]), .memWrEn(memWrEn),
  .memRdEn(memRdEn), .statusOut(statusOut), .busy(busy), .done(done),
  .entryKind(entryKind)
);

// File: tb/int_entry_seq_bench.sv
`timescale 1ns/1ps
module int_entry_seq_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic boundary = 0, nmiLine = 0, irqLine = 0, brkReq = 0, rtiReq = 0;
  logic [15:0] pcIn = 16'h0;
  logic [7:0]  spIn = 8'hFF, statusIn = 8'h20;
  logic [15:0] memAddr, pcOut;
  logic        memWrEn, memRdEn, busy, done;
  logic [7:0]  memWrData, spOut, statusOut;
  logic [7:0]  rdQ = 8'h00;
  logic [2:0]  entryKind;
  logic [3:0]  entryCost;

  int checks = 0, fails = 0;
  int wrCount = 0, badWr = 0;
  logic [15:0] lastRd = 16'h0, prevRd = 16'h0;
  logic [7:0] stackPage [256];
  logic pokeEn = 0;
  logic [7:0] pokeAddr = 0, pokeData = 0;

  always #10 clk = ~clk;

  int_entry_seq u_int_entry_seq (
    .clk(clk), .rstN(rstN), .boundary(boundary), .nmiLine(nmiLine),
    .irqLine(irqLine), .brkReq(brkReq), .rtiReq(rtiReq), .pcIn(pcIn),
    .spIn(spIn), .statusIn(statusIn), .memAddr(memAddr), .memWrEn(memWrEn),
    .memRdEn(memRdEn), .memWrData(memWrData), .memRdData(rdQ),
    .pcOut(pcOut), .spOut(spOut), .statusOut(statusOut), .busy(busy),
    .done(done), .entryKind(entryKind), .entryCost(entryCost)
  );

  function automatic logic [7:0] peek(input logic [15:0] a);
    case (a)
      16'hFFFA: return 8'h11;
      16'hFFFB: return 8'hA2;
      16'hFFFC: return 8'h00;
      16'hFFFD: return 8'hC0;
      16'hFFFE: return 8'h34;
      16'hFFFF: return 8'hE5;
      default:  return (a[15:8] == 8'h01) ? stackPage[a[7:0]] : 8'hEE;
    endcase
  endfunction

  always @(posedge clk) begin
    if (memRdEn) begin
      rdQ    <= peek(memAddr);
      prevRd <= lastRd;
      lastRd <= memAddr;
    end
    if (memWrEn) begin
      stackPage[memAddr[7:0]] <= memWrData;
      wrCount <= wrCount + 1;
      if (memAddr[15:8] != 8'h01) badWr <= badWr + 1;
    end else if (pokeEn) begin
      stackPage[pokeAddr] <= pokeData;
    end
  end

  typedef struct packed {
    logic [2:0]  op;   // 1 NMI, 2 IRQ, 3 break, 4 return
    logic [15:0] pc;
    logic [7:0]  sp;
    logic [7:0]  st;
    logic [7:0]  b0, b1, b2;
    logic [15:0] xPc;
    logic [7:0]  xSp;
    logic [7:0]  xSt;
    logic [3:0]  xCost;
    logic [2:0]  xKind;
    logic [1:0]  xWr;
    logic [7:0]  rq;
  } row_t;

  localparam int NROWS = 9;
  localparam row_t ROWS [NROWS] = '{
    '{3'd1, 16'h1234, 8'hFD, 8'h01, 8'h12, 8'h34, 8'h21, 16'hA211, 8'hFA, 8'h25, 4'd7, 3'd2, 2'd3, 8'd3}, // R3 NMI
    '{3'd2, 16'h8001, 8'hFF, 8'hD3, 8'h80, 8'h01, 8'hE3, 16'hE534, 8'hFC, 8'hE7, 4'd7, 3'd3, 2'd3, 8'd3}, // R3 IRQ
    '{3'd3, 16'h4FFF, 8'h80, 8'h00, 8'h50, 8'h00, 8'h30, 16'hE534, 8'h7D, 8'h34, 4'd7, 3'd5, 2'd3, 8'd8}, // R8
    '{3'd3, 16'hFFFF, 8'h02, 8'hC8, 8'h00, 8'h00, 8'hF8, 16'hE534, 8'hFF, 8'hFC, 4'd7, 3'd5, 2'd3, 8'd4}, // R4
    '{3'd4, 16'h0000, 8'hFC, 8'h88, 8'hC3, 8'h78, 8'h56, 16'h5678, 8'hFF, 8'hF3, 4'd6, 3'd6, 2'd0, 8'd9}, // R9
    '{3'd4, 16'h0000, 8'hFE, 8'h00, 8'h00, 8'h9A, 8'hBC, 16'hBC9A, 8'h01, 8'h30, 4'd6, 3'd6, 2'd0, 8'd4}, // R4
    '{3'd2, 16'h2222, 8'h40, 8'h04, 8'h00, 8'h00, 8'h00, 16'h2222, 8'h40, 8'h24, 4'd7, 3'd4, 2'd0, 8'd7}, // R7
    '{3'd2, 16'hABCD, 8'h10, 8'h9C, 8'h00, 8'h00, 8'h00, 16'hABCD, 8'h10, 8'hBC, 4'd7, 3'd4, 2'd0, 8'd7}, // R7
    '{3'd1, 16'h00FF, 8'h00, 8'h14, 8'h00, 8'hFF, 8'h24, 16'hA211, 8'hFD, 8'h24, 4'd7, 3'd2, 2'd3, 8'd3}  // R3, R4
  };

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    pokeEn = 1'b1; pokeAddr = a; pokeData = d;
    @(negedge clk);
    pokeEn = 1'b0;
  endtask

  // waits from a negedge until done is seen, then checks the pulse ends (R11)
  task automatic waitDone(input string tag);
    int n = 0;
    while (!done && n < 50) begin
      @(negedge clk);
      n++;
    end
    chk(tag, "done seen", {31'd0, done}, 32'd1);
    @(negedge clk);
    chk("R11", "done single pulse", {31'd0, done}, 32'd0);
  endtask

  task automatic request(input logic nmi, input logic irq, input logic brk, input logic rti);
    if (nmi) begin
      @(negedge clk);
      nmiLine = 1'b1;
    end
    @(negedge clk);
    nmiLine = 1'b0;
    boundary = 1'b1; irqLine = irq; brkReq = brk; rtiReq = rti;
    @(negedge clk);
    boundary = 1'b0; irqLine = 1'b0; brkReq = 1'b0; rtiReq = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    string tag;
    int w0;
    // reset state
    repeat (3) @(negedge clk);
    chk("R11", "done low in reset", {31'd0, done}, 32'd0);
    rstN = 1'b1;
    waitDone("R1");
    chk("R1", "reset pc", {16'd0, pcOut}, 32'hC000);
    chk("R1", "reset sp", {24'd0, spOut}, 32'hFF);
    chk("R1", "reset status", {24'd0, statusOut}, 32'h26);
    chk("R1", "reset kind", {29'd0, entryKind}, 32'd1);
    chk("R1", "reset cost", {28'd0, entryCost}, 32'd6);
    chk("R1", "first vector read", {16'd0, prevRd}, 32'hFFFC);
    chk("R1", "second vector read", {16'd0, lastRd}, 32'hFFFD);
    chk("R1", "no writes", wrCount, 0);
    chk("R2", "bit5 set", {31'd0, statusOut[5]}, 32'd1);
    chk("R2", "mask and zero bits", {30'd0, statusOut[2], statusOut[1]}, 32'd3);

    // table walk
    for (int i = 0; i < NROWS; i++) begin
      row_t r = ROWS[i];
      tag = $sformatf("R%0d row%0d", r.rq, i);
      if (r.op == 3'd4) begin
        poke(r.sp + 8'd1, r.b0);
        poke(r.sp + 8'd2, r.b1);
        poke(r.sp + 8'd3, r.b2);
      end
      @(negedge clk);
      pcIn = r.pc; spIn = r.sp; statusIn = r.st;
      w0 = wrCount;
      request(r.op == 3'd1, r.op == 3'd2, r.op == 3'd3, r.op == 3'd4);
      waitDone(tag);
      chk(tag, "pc", {16'd0, pcOut}, {16'd0, r.xPc});
      chk(tag, "sp", {24'd0, spOut}, {24'd0, r.xSp});
      chk(tag, "status", {24'd0, statusOut}, {24'd0, r.xSt});
      chk(tag, "cost", {28'd0, entryCost}, {28'd0, r.xCost});
      chk(tag, "kind", {29'd0, entryKind}, {29'd0, r.xKind});
      chk(tag, "write count", wrCount - w0, {30'd0, r.xWr});
      if (r.xWr == 2'd3) begin
        chk(tag, "stack pc high", {24'd0, stackPage[r.sp]}, {24'd0, r.b0});
        chk(tag, "stack pc low", {24'd0, stackPage[r.sp - 8'd1]}, {24'd0, r.b1});
        chk(tag, "stack status", {24'd0, stackPage[r.sp - 8'd2]}, {24'd0, r.b2});
      end
    end

    // R10: no boundary means no action
    @(negedge clk);
    pcIn = 16'h3000; spIn = 8'hF0; statusIn = 8'h20;
    irqLine = 1'b1; brkReq = 1'b1;
    repeat (5) @(negedge clk);
    chk("R10", "idle without boundary", {30'd0, busy, done}, 32'd0);
    irqLine = 1'b0; brkReq = 1'b0;

    // R10: IRQ over break, break over return
    request(1'b0, 1'b1, 1'b1, 1'b0);
    waitDone("R10");
    chk("R10", "irq beats break", {29'd0, entryKind}, 32'd3);
    request(1'b0, 1'b0, 1'b1, 1'b1);
    waitDone("R10");
    chk("R10", "break beats return", {29'd0, entryKind}, 32'd5);

    // R5: NMI before IRQ, IRQ afterwards
    request(1'b1, 1'b1, 1'b0, 1'b0);
    waitDone("R5");
    chk("R5", "nmi first", {29'd0, entryKind}, 32'd2);
    request(1'b0, 1'b1, 1'b0, 1'b0);
    waitDone("R5");
    chk("R5", "irq later", {29'd0, entryKind}, 32'd3);

    // R6: held-high NMI triggers once, edge remembered
    @(negedge clk);
    nmiLine = 1'b1;
    @(negedge clk);
    boundary = 1'b1;
    @(negedge clk);
    boundary = 1'b0;
    waitDone("R6");
    chk("R6", "held nmi first entry", {29'd0, entryKind}, 32'd2);
    @(negedge clk);
    boundary = 1'b1;
    @(negedge clk);
    boundary = 1'b0;
    chk("R6", "held nmi no second entry", {30'd0, busy, done}, 32'd0);
    nmiLine = 1'b0;
    @(negedge clk);
    nmiLine = 1'b1;
    @(negedge clk);
    nmiLine = 1'b0;
    repeat (4) @(negedge clk);
    boundary = 1'b1;
    @(negedge clk);
    boundary = 1'b0;
    chk("R6", "remembered edge taken", {31'd0, busy}, 32'd1);
    waitDone("R6");
    chk("R6", "remembered edge kind", {29'd0, entryKind}, 32'd2);

    chk("R12", "writes outside page one", badWr, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule